// File: doc/BRIEF.md
# I/O-Mode DMA Channel

This block is one DMA channel that moves data between a stepping memory address and a fixed peripheral address. Each request moves one byte or one 16-bit word. The block does this with a read cycle from the source and then a write cycle to the destination, on a simple synchronous bus master port. The peripheral address is an 8-bit register value. The upper bits of that address are forced to ones, so the peripheral side always sits at the top 256 bytes of the address space. The peripheral address never moves.

There are two request inputs. One is the serial receive-data-full request, which moves data from the peripheral into memory. The other covers every other source, which moves data from memory to the peripheral. A 16-bit count sets how many transfers the block runs. When the count runs out, the channel turns itself off and raises a sticky done flag. This flag can also drive an interrupt. The CPU loads the registers through a small write/read port. While a transfer is in flight, the channel ignores writes to that port.

Top module: `dma_io_channel`

## Requirements
- R1: After reset, the memory address, peripheral address, count and control registers read back as zero. `bus_rd`, `bus_wr`, `done`, `irq` and `err` are all low.
- R2: A served request gives exactly one read cycle and then one write cycle. `bus_rd` or `bus_wr` stays high until the cycle in which `bus_ready` is high, and the two strobes are never high together.
- R3: For a `req_rx` request, the read goes to {16'hFFFF, peripheral register} and the write goes to the memory address.
- R4: For a `req_other` request, the read goes to the memory address and the write goes to {16'hFFFF, peripheral register}.
- R5: After each transfer, the memory address moves by 1 (byte) or 2 (word), up or down as set by control bit 2 (1 = down), and wraps modulo 2^24. The peripheral address does not change.
- R6: The count (`reg_sel`=2) drops by one per transfer. When it goes from 1 to 0, control bit 0 (enable) clears and `done` (control readback bit 5) sets and stays set. Later requests make no bus cycle.
- R7: If word mode (control bit 1) is set and the memory address is odd, a request makes no bus cycle. Instead, `err` (control readback bit 6) sets, enable clears, and the count is unchanged.
- R8: A request that arrives while a transfer is running is held and served afterwards. When both request kinds are pending, the `req_rx` one is served first.
- R9: While a transfer is in progress, register writes have no effect.
- R10: `irq` equals `done` AND control bit 3. A control write with bit 4 set clears `done` and `err`.
- R11: `bus_word` shows the unit size. A byte transfer writes the low 8 bits of the read data with the upper 8 bits zero. A word transfer writes all 16 bits.
- R12: Register select codes are 0 = memory address (24 bits), 1 = peripheral address (8 bits), 2 = count (16 bits) and 3 = control. Each reads back on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and readback |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Readback of the selected register |
| req_rx | input | 1 | Receive-data-full request (peripheral to memory) |
| req_other | input | 1 | Any other request (memory to peripheral) |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | 1 = word access, 0 = byte access |
| bus_ready | input | 1 | Ends the current bus cycle |
| done | output | 1 | Sticky end-of-block flag |
| irq | output | 1 | Interrupt, done gated by its enable |
| err | output | 1 | Sticky odd-address word error |

## Verification
The transfer path is tried with a set of vectors that cover both request kinds, byte and word size, up and down stepping, 0 to 3 wait cycles, and addresses that wrap at both ends of the space. Swapping the request kinds tells the two directions apart. Byte against word tells the step size and the zeroing of the upper data byte apart. Address 0 and address 0xFFFFFF expose any carry or borrow error in the stepping logic. Directed cases then cover:
- count exhaustion,
- the odd-address fault,
- two requests at once,
- a register write that lands during a transfer.

// File: rtl/dma_io_pkg.sv
package dma_io_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_e;

   localparam logic [1:0] SEL_MEM  = 2'd0;
   localparam logic [1:0] SEL_PER  = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int CB_EN    = 0;
   localparam int CB_WORD  = 1;
   localparam int CB_DOWN  = 2;
   localparam int CB_IRQEN = 3;
   localparam int CB_CLR   = 4;
   localparam int CB_DONE  = 5;
   localparam int CB_ERR   = 6;
endpackage

// File: rtl/dma_io_regs.sv
module dma_io_regs
   import dma_io_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int PER_W   = 8,
   parameter int CNT_W   = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              step,
   input  logic              odd_err,
   output logic [ADDR_W-1:0] mem_q,
   output logic [PER_W-1:0]  per_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              en_q,
   output logic              word_q,
   output logic              down_q,
   output logic              irqen_q,
   output logic              done_q,
   output logic              err_q
);
   logic              word_in;
   logic [ADDR_W-1:0] step_amt;
   logic [ADDR_W-1:0] mem_next;

   generate
      if (WORD_EN) begin : g_word
         assign word_in = reg_wdata[CB_WORD];
      end else begin : g_byte_only
         assign word_in = 1'b0;
      end
   endgenerate

   always_comb begin
      step_amt = word_q ? ADDR_W'(2) : ADDR_W'(1);
      mem_next = down_q ? (mem_q - step_amt) : (mem_q + step_amt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q   <= '0;
         per_q   <= '0;
         cnt_q   <= '0;
         en_q    <= 1'b0;
         word_q  <= 1'b0;
         down_q  <= 1'b0;
         irqen_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (reg_wr && !busy) begin
            case (reg_sel)
               SEL_MEM: mem_q <= reg_wdata;
               SEL_PER: per_q <= reg_wdata[PER_W-1:0];
               SEL_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
               default: begin
                  en_q    <= reg_wdata[CB_EN];
                  word_q  <= word_in;
                  down_q  <= reg_wdata[CB_DOWN];
                  irqen_q <= reg_wdata[CB_IRQEN];
                  if (reg_wdata[CB_CLR]) begin
                     done_q <= 1'b0;
                     err_q  <= 1'b0;
                  end
               end
            endcase
         end
         if (step) begin
            mem_q <= mem_next;
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               en_q   <= 1'b0;
               done_q <= 1'b1;
            end
         end
         if (odd_err) begin
            err_q <= 1'b1;
            en_q  <= 1'b0;
         end
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_MEM: reg_rdata = mem_q;
         SEL_PER: reg_rdata = ADDR_W'(per_q);
         SEL_CNT: reg_rdata = ADDR_W'(cnt_q);
         default: reg_rdata = ADDR_W'({err_q, done_q, 1'b0, irqen_q,
                                       down_q, word_q, en_q});
      endcase
   end
endmodule

// File: rtl/dma_io_seq.sv
module dma_io_seq
   import dma_io_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              word,
   input  logic              cnt_nz,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [ADDR_W-1:0] per_addr,
   input  logic              req_rx,
   input  logic              req_other,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              busy,
   output logic              step,
   output logic              odd_err,
   output logic              cur_rx
);
   localparam int HALF_W = DATA_W / 2;

   dma_state_e        state;
   logic              pend_rx, pend_ot;
   logic              take, take_rx, take_ot, odd;
   logic [DATA_W-1:0] data_q;

   always_comb begin
      take    = (state == ST_IDLE) && en && cnt_nz && (pend_rx || pend_ot);
      take_rx = take && pend_rx;
      take_ot = take && !pend_rx;
      odd     = word && mem_addr[0];
      odd_err = take && odd;
      busy    = (state != ST_IDLE);
      bus_rd  = (state == ST_RD);
      bus_wr  = (state == ST_WR);
      step    = bus_wr && bus_ready;
      if (bus_rd) bus_addr = cur_rx ? per_addr : mem_addr;
      else        bus_addr = cur_rx ? mem_addr : per_addr;
      bus_wdata = word ? data_q : {{HALF_W{1'b0}}, data_q[HALF_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pend_rx <= 1'b0;
         pend_ot <= 1'b0;
         cur_rx  <= 1'b0;
         data_q  <= '0;
      end else begin
         pend_rx <= en && ((pend_rx && !take_rx) || req_rx);
         pend_ot <= en && ((pend_ot && !take_ot) || req_other);
         case (state)
            ST_IDLE: if (take && !odd) begin
               state  <= ST_RD;
               cur_rx <= pend_rx;
            end
            ST_RD: if (bus_ready) begin
               data_q <= bus_rdata;
               state  <= ST_WR;
            end
            default: if (bus_ready) state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_io_channel.sv
module dma_io_channel
   import dma_io_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int PER_W   = 8,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter bit WORD_EN = 1'b1,
   parameter bit HAS_IRQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              req_rx,
   input  logic              req_other,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_word,
   input  logic              bus_ready,
   output logic              done,
   output logic              irq,
   output logic              err
);
   localparam int ONES_W = ADDR_W - PER_W;

   generate
      if (PER_W >= ADDR_W) begin : g_bad_per
         $error("PER_W must be narrower than ADDR_W");
      end
      if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("DATA_W must be even and at least 16");
      end
      if (CNT_W > ADDR_W || ADDR_W < 8) begin : g_bad_cnt
         $error("CNT_W must fit in ADDR_W, ADDR_W at least 8");
      end
   endgenerate

   logic [ADDR_W-1:0] mem_q;
   logic [PER_W-1:0]  per_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] per_addr;
   logic en_q, word_q, down_q, irqen_q, done_q, err_q;
   logic busy, step, odd_err, cur_rx;

   assign per_addr = {{ONES_W{1'b1}}, per_q};
   assign bus_word = word_q;
   assign done     = done_q;
   assign err      = err_q;

   generate
      if (HAS_IRQ) begin : g_irq
         assign irq = done_q && irqen_q;
      end else begin : g_no_irq
         assign irq = 1'b0;
      end
   endgenerate

   dma_io_regs #(
      .ADDR_W(ADDR_W), .PER_W(PER_W), .CNT_W(CNT_W), .WORD_EN(WORD_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .step(step), .odd_err(odd_err), .mem_q(mem_q), .per_q(per_q),
      .cnt_q(cnt_q), .en_q(en_q), .word_q(word_q), .down_q(down_q),
      .irqen_q(irqen_q), .done_q(done_q), .err_q(err_q)
   );

   dma_io_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en_q), .word(word_q),
      .cnt_nz(cnt_q != '0), .mem_addr(mem_q), .per_addr(per_addr),
      .req_rx(req_rx), .req_other(req_other), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .busy(busy), .step(step),
      .odd_err(odd_err), .cur_rx(cur_rx)
   );
endmodule

// File: rtl/dma_io_checker.sv
module dma_io_checker #(
   parameter int ADDR_W = 24,
   parameter int PER_W  = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_word,
   input logic              bus_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [ADDR_W-1:0] mem_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              cur_rx,
   input logic              done,
   input logic              irq,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic [ADDR_W-1:0] reg_wdata
);
   localparam int ONES_W = ADDR_W - PER_W;

   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   p_rx_src_per_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && cur_rx) |-> (bus_addr[ADDR_W-1:PER_W] == {ONES_W{1'b1}}));

   p_ot_dst_per_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !cur_rx) |-> (bus_addr[ADDR_W-1:PER_W] == {ONES_W{1'b1}}));

   p_no_start_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd) |-> (cnt_q != '0));

   p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(reg_wr && reg_sel == 2'd3 && reg_wdata[4])) |=> done);

   p_word_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && bus_word) |-> !mem_q[0]);

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_ready) |=> ($stable(mem_q) && $stable(cnt_q)));

   p_irq_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
endmodule

bind dma_io_channel dma_io_checker #(
   .ADDR_W(ADDR_W), .PER_W(PER_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_word(bus_word), .bus_ready(bus_ready), .bus_addr(bus_addr),
   .mem_q(mem_q), .cnt_q(cnt_q), .cur_rx(cur_rx), .done(done), .irq(irq),
   .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/tb_dma_io_channel.sv
module tb_dma_io_channel;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        rx;
      logic        word;
      logic        down;
      logic [23:0] mem;
      logic [7:0]  per;
      logic [1:0]  wt;
      logic [23:0] e_rd;
      logic [23:0] e_wr;
      logic [15:0] e_data;
      logic [23:0] e_mem;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b0, 1'b0, 24'h001000, 8'h40, 2'd0, 24'h001000, 24'hFFFF40, 16'h00C3, 24'h001001},
      '{1'b1, 1'b0, 1'b1, 24'h002005, 8'h81, 2'd1, 24'hFFFF81, 24'h002005, 16'h0042, 24'h002004},
      '{1'b0, 1'b1, 1'b0, 24'h010ABC, 8'h10, 2'd2, 24'h010ABC, 24'hFFFF10, 16'hAF7F, 24'h010ABE},
      '{1'b1, 1'b1, 1'b1, 24'h000100, 8'hFE, 2'd3, 24'hFFFFFE, 24'h000100, 16'h5A3D, 24'h0000FE},
      '{1'b0, 1'b1, 1'b1, 24'h000000, 8'h00, 2'd0, 24'h000000, 24'hFFFF00, 16'hA5C3, 24'hFFFFFE},
      '{1'b1, 1'b0, 1'b0, 24'hFFFFFF, 8'h7F, 2'd1, 24'hFFFF7F, 24'hFFFFFF, 16'h00BC, 24'h000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [23:0] reg_wdata = '0;
   logic [23:0] reg_rdata;
   logic        req_rx = 1'b0, req_other = 1'b0;
   logic [23:0] bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        bus_rd, bus_wr, bus_word, bus_ready;
   logic        done, irq, err;

   int          checks = 0, errors = 0;
   int          wait_cfg = 0;
   int          wcnt = 0;
   int          nwr = 0;
   logic [23:0] rd_last = '0;
   logic [23:0] wr_log [8];
   logic [15:0] wd_log [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_io_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_rx(req_rx),
      .req_other(req_other), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_ready(bus_ready), .done(done), .irq(irq),
      .err(err)
   );

   assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;
   assign bus_ready = (bus_rd || bus_wr) && (wcnt >= wait_cfg);

   always @(posedge clk) begin
      if (bus_rd || bus_wr) begin
         if (bus_ready) begin
            wcnt <= 0;
            if (bus_rd) rd_last <= bus_addr;
            if (bus_wr) begin
               wr_log[nwr % 8] <= bus_addr;
               wd_log[nwr % 8] <= bus_wdata;
               nwr <= nwr + 1;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [23:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] sel, output logic [23:0] val);
      @(negedge clk);
      reg_sel = sel;
      #1 val = reg_rdata;
   endtask

   task automatic pulse(input logic rx, input logic ot);
      @(negedge clk);
      req_rx = rx; req_other = ot;
      @(negedge clk);
      req_rx = 1'b0; req_other = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] v;
      int          base;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         rreg(2'(s), v);
         chk("R1 reg readback", v, 24'h0);
      end
      chk("R1 strobes/flags", {19'h0, bus_rd, bus_wr, done, irq, err}, 24'h0);
      rst_n = 1'b1;
      idle(2);

      // R2 R3 R4 R5 R11 R12: vector table
      for (int i = 0; i < 6; i++) begin
         wait_cfg = int'(VECS[i].wt);
         wreg(2'd0, VECS[i].mem);
         wreg(2'd1, {16'h0, VECS[i].per});
         wreg(2'd2, 24'd3);
         wreg(2'd3, {21'h0, VECS[i].down, VECS[i].word, 1'b1});
         base = nwr;
         pulse(VECS[i].rx, !VECS[i].rx);
         idle(20);
         chk("R2 one write per request", 24'(nwr - base), 24'd1);
         chk(VECS[i].rx ? "R3 read addr" : "R4 read addr", rd_last, VECS[i].e_rd);
         chk(VECS[i].rx ? "R3 write addr" : "R4 write addr", wr_log[base % 8], VECS[i].e_wr);
         chk("R11 write data", {8'h0, wd_log[base % 8]}, {8'h0, VECS[i].e_data});
         rreg(2'd0, v); chk("R5 memory step", v, VECS[i].e_mem);
         rreg(2'd1, v); chk("R5 peripheral fixed", v, {16'h0, VECS[i].per});
         rreg(2'd2, v); chk("R6 count decrement", v, 24'd2);
      end

      // R6 R10: count exhaustion, done, irq, clear
      wait_cfg = 1;
      wreg(2'd0, 24'h000300);
      wreg(2'd2, 24'd2);
      wreg(2'd3, 24'h000009);
      pulse(1'b0, 1'b1); idle(12);
      pulse(1'b0, 1'b1); idle(12);
      rreg(2'd2, v); chk("R6 count zero", v, 24'd0);
      rreg(2'd3, v); chk("R6 done set enable clear", v & 24'h21, 24'h20);
      chk("R10 irq with done", {23'h0, irq}, 24'd1);
      base = nwr;
      pulse(1'b1, 1'b1); idle(12);
      chk("R6 no cycle after end", 24'(nwr - base), 24'd0);
      chk("R6 done sticky", {23'h0, done}, 24'd1);
      wreg(2'd3, 24'h000010);
      chk("R10 clear done/irq", {22'h0, done, irq}, 24'd0);

      // R7: odd address word fault
      wreg(2'd0, 24'h000401);
      wreg(2'd2, 24'd4);
      wreg(2'd3, 24'h000003);
      base = nwr;
      pulse(1'b0, 1'b1); idle(12);
      chk("R7 no bus cycle", 24'(nwr - base), 24'd0);
      rreg(2'd3, v); chk("R7 err set enable clear", v & 24'h41, 24'h40);
      rreg(2'd2, v); chk("R7 count unchanged", v, 24'd4);
      wreg(2'd3, 24'h000010);
      chk("R10 clear err", {23'h0, err}, 24'd0);

      // R8: simultaneous requests, rx first; request held during transfer
      wait_cfg = 3;
      wreg(2'd0, 24'h000200);
      wreg(2'd1, 24'h000022);
      wreg(2'd2, 24'd5);
      wreg(2'd3, 24'h000001);
      base = nwr;
      pulse(1'b1, 1'b1);
      idle(40);
      chk("R8 both served", 24'(nwr - base), 24'd2);
      chk("R8 rx served first", wr_log[base % 8], 24'h000200);
      chk("R8 other served second", wr_log[(base + 1) % 8], 24'hFFFF22);
      base = nwr;
      pulse(1'b0, 1'b1);
      idle(2);
      pulse(1'b1, 1'b0);
      idle(40);
      chk("R8 held request served", 24'(nwr - base), 24'd2);
      chk("R8 held rx write addr", wr_log[(base + 1) % 8], 24'h000203);

      // R9: register write during a transfer is dropped
      wreg(2'd0, 24'h000500);
      wreg(2'd2, 24'd4);
      wreg(2'd3, 24'h000001);
      @(negedge clk);
      req_other = 1'b1;
      @(negedge clk);
      req_other = 1'b0;
      idle(1);
      wreg(2'd0, 24'h123456);
      idle(20);
      rreg(2'd0, v); chk("R9 write ignored while busy", v, 24'h000501);
      rreg(2'd2, v); chk("R9 count after transfer", v, 24'd3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule